// File: doc/BRIEF.md
# Power-On Ready and Slave Address Recall

This block decides when a supply-monitored device may call itself ready, and which serial-bus slave address it answers to. Two comparator outputs come in: one says the supply is above the analog power-on level, the other says it is above the lower digital power-on level. Both pass through a synchronizer before any logic acts on them.

While the analog comparator reads low, the block holds its active-low ready flag high and presents a fixed default slave address. The default is 7'h51, which is A2h in 8-bit form. Once the analog comparator reads high, a settle timer runs for a parameterised time. The default is 400 µs, which leaves room for the recall and still clears the flag well before 500 µs. When the timer expires, the block sends one read request to the nonvolatile store. When the store answers, the block latches the configured address and clears the ready flag. The bus-enable output depends only on the digital comparator, so the serial bus works before the device is ready.

Any loss of the analog supply returns the block to the default address with the flag set, and the whole sequence restarts. A synchronous active-high reset does the same.

Top module: `por_ready_seq`

## Requirements
- R1: In the cycle after reset is sampled high, `ready_n_o`=1, `slave_addr_o`=7'h51, `bus_en_o`=0 and `nvm_req_o`=0.
- R2: When `vcc_ana_ok_i` goes low, the block returns `ready_n_o` to 1 and `slave_addr_o` to 7'h51 on the third rising edge after the drop (two synchronizer stages plus one state register). This applies in every phase: settling, fetching or ready. A later rise restarts the full settle time.
- R3: After `vcc_ana_ok_i` rises from the off state, `nvm_req_o` is high for exactly one cycle. That cycle follows rising edge number SETTLE_CYC+3, where SETTLE_CYC = CLK_FREQ_HZ·SETTLE_US/10^6, which is 400 cycles with the default parameters. `ready_n_o` stays 1 until then.
- R4: While a request is outstanding, a rising edge with `nvm_valid_i`=1 loads `nvm_addr_i` (the upper seven bits of the stored address byte) into `slave_addr_o` and clears `ready_n_o` at that same edge.
- R5: `nvm_valid_i` has no effect outside the fetch phase. In the off state the address stays 7'h51. Once ready, the latched address does not change.
- R6: If the analog loss reaches the state register on the same edge as `nvm_valid_i`, the loss wins: `ready_n_o` stays 1 and the address stays 7'h51.
- R7: `bus_en_o` follows `vcc_dig_ok_i` with a latency of three rising edges, whatever the value of `ready_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vcc_ana_ok_i | input | 1 | Supply above the analog power-on level (asynchronous) |
| vcc_dig_ok_i | input | 1 | Supply above the digital power-on level (asynchronous) |
| nvm_req_o | output | 1 | One-cycle read request for the stored address |
| nvm_valid_i | input | 1 | Stored address is present on `nvm_addr_i` |
| nvm_addr_i | input | 7 | Stored slave address, 7-bit form |
| ready_n_o | output | 1 | Active-low ready status bit |
| slave_addr_o | output | 7 | Active 7-bit slave address |
| bus_en_o | output | 1 | Serial bus may be used |

## Verification
The close case is a supply loss that reaches the state register on the same edge as the store's answer. The bench provokes it by answering a request late: it drops the analog comparator right after the request appears, then raises valid exactly two cycles later, so both act on one edge. The check is that the ready flag stays high and the default address remains in force, and that nothing is left behind to affect the next power-up.

// File: rtl/por_ready_pkg.sv
package por_ready_pkg;

    typedef enum logic [1:0] {
        PS_OFF,
        PS_SETTLE,
        PS_FETCH,
        PS_LIVE
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e  state;
        logic        rdy_n;
        logic        req;
        logic [6:0]  addr;
        logic        bus_en;
    } seq_regs_t;

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= d_i[b];
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
        end
        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/por_settle_timer.sv
module por_settle_timer #(
    parameter int unsigned CYCLES = 400
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic expire_o
);

    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && (cnt_q == LAST);
        if (!run_i)        cnt_d = '0;
        else if (expire_o) cnt_d = cnt_q;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // R3: each settle period starts counting from zero
    a_r3_fresh_start: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(run_i) |-> (cnt_q == '0));

endmodule

// File: rtl/por_ready_seq.sv
module por_ready_seq
    import por_ready_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ   = 1_000_000,
    parameter int unsigned SETTLE_US     = 400,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter logic [6:0]  DEFAULT_ADDR7 = 7'h51
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       vcc_ana_ok_i,
    input  logic       vcc_dig_ok_i,
    output logic       nvm_req_o,
    input  logic       nvm_valid_i,
    input  logic [6:0] nvm_addr_i,
    output logic       ready_n_o,
    output logic [6:0] slave_addr_o,
    output logic       bus_en_o
);

    localparam longint unsigned SETTLE_RAW =
        (64'(CLK_FREQ_HZ) * 64'(SETTLE_US)) / 64'd1_000_000;
    localparam int unsigned SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);

    localparam seq_regs_t RESET_REGS = '{
        state:  PS_OFF,
        rdy_n:  1'b1,
        req:    1'b0,
        addr:   DEFAULT_ADDR7,
        bus_en: 1'b0
    };

    logic [1:0] sync_s;
    logic       ana_s, dig_s;
    logic       tmr_run, tmr_done;
    seq_regs_t  d, q;

    por_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({vcc_dig_ok_i, vcc_ana_ok_i}),
        .q_o   (sync_s)
    );

    assign ana_s = sync_s[0];
    assign dig_s = sync_s[1];

    por_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (tmr_run),
        .expire_o (tmr_done)
    );

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        d.bus_en = dig_s;
        tmr_run  = (q.state == PS_SETTLE);

        case (q.state)
            PS_OFF: begin
                if (ana_s) d.state = PS_SETTLE;
            end
            PS_SETTLE: begin
                if (tmr_done) begin
                    d.state = PS_FETCH;
                    d.req   = 1'b1;
                end
            end
            PS_FETCH: begin
                if (nvm_valid_i) begin
                    d.state = PS_LIVE;
                    d.rdy_n = 1'b0;
                    d.addr  = nvm_addr_i;
                end
            end
            default: ;
        endcase

        // supply loss overrides every phase, including a same-edge answer
        if (!ana_s) begin
            d.state = PS_OFF;
            d.rdy_n = 1'b1;
            d.req   = 1'b0;
            d.addr  = DEFAULT_ADDR7;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= RESET_REGS;
        else       q <= d;
    end

    assign nvm_req_o    = q.req;
    assign ready_n_o    = q.rdy_n;
    assign slave_addr_o = q.addr;
    assign bus_en_o     = q.bus_en;

    // R1: reset forces the default outputs
    a_r1_reset_defaults: assert property (@(posedge clk_i)
        rst_i |=> (ready_n_o && !bus_en_o && !nvm_req_o && slave_addr_o == DEFAULT_ADDR7));

    // R2: a low analog supply yields not-ready with the default address
    a_r2_off_defaults: assert property (@(posedge clk_i) disable iff (rst_i)
        !ana_s |=> (ready_n_o && !nvm_req_o && slave_addr_o == DEFAULT_ADDR7));

    // R3: the recall request lasts one cycle
    a_r3_req_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        nvm_req_o |=> !nvm_req_o);

    // R4: ready is only reached through an answer from the store
    a_r4_ready_from_valid: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ready_n_o) |-> $past(nvm_valid_i));

    // R5: with supply held, the latched address stays put
    a_r5_live_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ready_n_o && ana_s) |=> (!ready_n_o && $stable(slave_addr_o)));

endmodule

// File: tb/test_por_ready_seq.sv
module test_por_ready_seq;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 400;
    localparam int UP_EDGES   = SETTLE + 3;
    localparam logic [6:0] DEF7 = 7'h51;

    // stimulus address / expected active address
    localparam logic [13:0] VECS [4] = '{
        {7'h50, 7'h50},
        {7'h1E, 7'h1E},
        {7'h7F, 7'h7F},
        {7'h00, 7'h00}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       vcc_ana, vcc_dig;
    logic       nvm_req, nvm_valid;
    logic [6:0] nvm_addr;
    logic       ready_n, bus_en;
    logic [6:0] slave_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    por_ready_seq #(
        .CLK_FREQ_HZ(1_000_000), .SETTLE_US(400), .SYNC_STAGES(2), .DEFAULT_ADDR7(7'h51)
    ) i_por_ready_seq (
        .clk_i        (clk),
        .rst_i        (rst),
        .vcc_ana_ok_i (vcc_ana),
        .vcc_dig_ok_i (vcc_dig),
        .nvm_req_o    (nvm_req),
        .nvm_valid_i  (nvm_valid),
        .nvm_addr_i   (nvm_addr),
        .ready_n_o    (ready_n),
        .slave_addr_o (slave_addr),
        .bus_en_o     (bus_en)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_up(output int edges);
        vcc_ana = 1'b1;
        edges = 0;
        do begin
            step(1);
            edges++;
        end while (!nvm_req && edges < 2000);
    endtask

    task automatic answer(input logic [6:0] a);
        nvm_valid = 1'b1;
        nvm_addr  = a;
        step(1);
        nvm_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int e;
        rst = 1'b1; vcc_ana = 1'b0; vcc_dig = 1'b0;
        nvm_valid = 1'b0; nvm_addr = '0;
        step(3);
        chk("R1 ready_n", ready_n, 1);
        chk("R1 addr", slave_addr, DEF7);
        chk("R1 bus_en", bus_en, 0);
        chk("R1 req", nvm_req, 0);
        rst = 1'b0;

        // R7: bus usable from the digital level alone
        vcc_dig = 1'b1;
        step(2);
        chk("R7 bus_en latency", bus_en, 0);
        step(1);
        chk("R7 bus_en", bus_en, 1);
        chk("R7 ready_n still 1", ready_n, 1);

        // R5: answer while off is ignored
        answer(7'h10);
        chk("R5 off addr", slave_addr, DEF7);
        chk("R5 off ready_n", ready_n, 1);

        // table of power-up cycles
        for (int i = 0; i < 4; i++) begin
            power_up(e);
            chk("R3 request timing", e, UP_EDGES);
            chk("R3 ready_n before answer", ready_n, 1);
            answer(VECS[i][13:7]);
            chk("R3 req one cycle", nvm_req, 0);
            chk("R4 ready_n", ready_n, 0);
            chk("R4 addr", slave_addr, VECS[i][6:0]);
            answer(~VECS[i][13:7]);
            chk("R5 live addr", slave_addr, VECS[i][6:0]);
            vcc_ana = 1'b0;
            step(2);
            chk("R2 latency", ready_n, 0);
            step(1);
            chk("R2 ready_n", ready_n, 1);
            chk("R2 addr", slave_addr, DEF7);
            step(2);
        end

        // R2/R3: drop during settle restarts the full wait
        vcc_ana = 1'b1;
        step(100);
        chk("R3 no early req", nvm_req, 0);
        vcc_ana = 1'b0;
        step(3);
        power_up(e);
        chk("R3 restart timing", e, UP_EDGES);
        answer(7'h2D);
        chk("R4 addr after restart", slave_addr, 7'h2D);

        // R6: loss and answer on the same edge
        vcc_ana = 1'b0;
        step(3);
        power_up(e);
        vcc_ana = 1'b0;
        step(2);
        answer(7'h62);
        chk("R6 ready_n", ready_n, 1);
        chk("R6 addr", slave_addr, DEF7);
        step(5);
        chk("R6 stays off", ready_n, 1);

        // R1: reset while live
        power_up(e);
        answer(7'h22);
        chk("R4 live before reset", ready_n, 0);
        rst = 1'b1;
        step(1);
        chk("R1 reset ready_n", ready_n, 1);
        chk("R1 reset addr", slave_addr, DEF7);
        chk("R1 reset bus_en", bus_en, 0);
        rst = 1'b0;
        step(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule